// File: doc/BRIEF.md
# Bridge Excitation Phase Generator

This block drives the polarity-reversal switches of a resistive bridge sensor that runs on alternating excitation. It makes a forward drive and a reverse drive that alternate as a square wave, plus a registered inverted copy of each, so that either sense of switch can be used. Whenever one drive is released, both drives stay low for exactly one clock before the other is raised. This means both switch pairs can never conduct at the same time.

The half-period is given as a count of master clocks on an input. The dead cycle is taken out of the half that is starting. When excitation is disabled, the outputs rest at fixed levels that apply normal polarity. A polarity flag and a one-cycle change pulse travel with the drives, so that a downstream converter can tell which polarity is applied and can drop the samples taken while the bridge settles. The switches, the bridge and the converter's filtering are outside this block.

Top module: `bridge_exc_phase_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the outputs are `fwd_o`=1, `fwd_n_o`=0, `rvs_o`=0, `rvs_n_o`=1, `pol_rev_o`=0 and `pol_step_o`=0. The half-period counter is cleared, so a later enable starts a fresh sequence.
- R2: While excitation stays disabled (`exc_en`=0), the outputs hold the R1 levels.
- R3: `exc_en`=1 is sampled in the idle state. From the next edge, a forward half of N cycles follows, with `fwd_o`=1 and `rvs_o`=0. No output changes on the enable edge itself.
- R4: Every later half lasts N clocks. Its first cycle has both drives low. In the remaining N-1 cycles the incoming drive is high. Reverse halves and forward halves alternate, so the full period is 2N clocks.
- R5: `fwd_o` and `rvs_o` are never high together. Every both-low interval while running lasts exactly one clock.
- R6: `fwd_n_o` is always the complement of `fwd_o`, and `rvs_n_o` is always the complement of `rvs_o`.
- R7: `pol_rev_o` is 1 through a whole reverse half, including its dead cycle, and 0 otherwise. `pol_step_o` is 1 for exactly the one cycle in which `pol_rev_o` differs from its previous value. This includes the dead cycle that leads back to idle.
- R8: Clearing `exc_en` takes effect only at the end of the current half. If that half is forward, the outputs go straight to idle with no dead cycle. If it is reverse, the reverse half completes, one dead cycle follows (`pol_step_o`=1, `pol_rev_o`=0), and then the outputs go idle.
- R9: `half_period` is captured only when a new half is loaded: on the enable edge, or on the last cycle of a half when the next half is a running half. A change in the middle of a half does not alter that half's length.
- R10: A `half_period` value of 0 or 1 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_en | input | 1 | Enables alternating excitation |
| half_period | input | CNT_W | Half-period length N in clocks |
| fwd_o | output | 1 | Forward-polarity drive, high = normal polarity |
| fwd_n_o | output | 1 | Complement of fwd_o |
| rvs_o | output | 1 | Reverse-polarity drive, high = reversed polarity |
| rvs_n_o | output | 1 | Complement of rvs_o |
| pol_rev_o | output | 1 | 1 while reversed polarity is being applied |
| pol_step_o | output | 1 | One-cycle pulse on each polarity change |

## Verification
The bench builds the block with `CNT_W` = 4, so that half-periods run only from 2 to 15 clocks. This keeps full waveforms short enough to be compared cycle by cycle. The narrow width also lets the bench reach both the clamped values 0 and 1 and the largest count, 15, in separate runs. It reaches the mid-half change of `half_period`, and a disable in both the forward and the reverse half, within a few dozen cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FWD   = 3'd1,
    ST_GAP_R = 3'd2,
    ST_RVS   = 3'd3,
    ST_GAP_F = 3'd4,
    ST_GAP_I = 3'd5
  } exc_state_t;

  typedef struct packed {
    logic fwd;
    logic rvs;
    logic rev;
    logic step;
  } exc_drive_t;

  // Output levels belonging to each state; the dead states drive both low.
  function automatic exc_drive_t exc_decode(exc_state_t s);
    exc_drive_t d;
    d = '{fwd: 1'b0, rvs: 1'b0, rev: 1'b0, step: 1'b0};
    case (s)
      ST_IDLE:  d.fwd = 1'b1;
      ST_FWD:   d.fwd = 1'b1;
      ST_GAP_R: begin d.rev = 1'b1; d.step = 1'b1; end
      ST_RVS:   begin d.rvs = 1'b1; d.rev = 1'b1; end
      ST_GAP_F: d.step = 1'b1;
      ST_GAP_I: d.step = 1'b1;
      default:  d.fwd = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/exc_len_latch.sv
module exc_len_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] half_period,
  output logic [CNT_W-1:0] last_idx
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_clamped;

  assign len_clamped = (half_period < MIN_LEN) ? MIN_LEN : half_period;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= MIN_LEN;
    end else if (load) begin
      len_q <= len_clamped;
    end
  end

  assign last_idx = len_q - CNT_W'(1);

endmodule

// File: rtl/exc_half_timer.sv
module exc_half_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_zero,
  input  logic             go_one,
  input  logic             go_inc,
  input  logic [CNT_W-1:0] last_idx,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (go_zero) begin
      cnt_q <= '0;
    end else if (go_one) begin
      cnt_q <= CNT_W'(1);
    end else if (go_inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign at_last = (cnt_q == last_idx);

endmodule

// File: rtl/exc_phase_fsm.sv
module exc_phase_fsm
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exc_en,
  input  logic       at_last,
  output exc_state_t st_nxt,
  output logic       len_load,
  output logic       go_zero,
  output logic       go_one,
  output logic       go_inc
);
  exc_state_t st_q;

  always_comb begin
    st_nxt   = st_q;
    len_load = 1'b0;
    go_zero  = 1'b0;
    go_one   = 1'b0;
    go_inc   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        go_zero = 1'b1;
        if (exc_en) begin
          st_nxt   = ST_FWD;
          len_load = 1'b1;
        end
      end
      ST_FWD: begin
        if (at_last) begin
          go_zero = 1'b1;
          if (exc_en) begin
            st_nxt   = ST_GAP_R;
            len_load = 1'b1;
          end else begin
            st_nxt = ST_IDLE;
          end
        end else begin
          go_inc = 1'b1;
        end
      end
      ST_GAP_R: begin
        st_nxt = ST_RVS;
        go_one = 1'b1;
      end
      ST_RVS: begin
        if (at_last) begin
          go_zero = 1'b1;
          if (exc_en) begin
            st_nxt   = ST_GAP_F;
            len_load = 1'b1;
          end else begin
            st_nxt = ST_GAP_I;
          end
        end else begin
          go_inc = 1'b1;
        end
      end
      ST_GAP_F: begin
        st_nxt = ST_FWD;
        go_one = 1'b1;
      end
      ST_GAP_I: begin
        st_nxt  = ST_IDLE;
        go_zero = 1'b1;
      end
      default: begin
        st_nxt  = ST_IDLE;
        go_zero = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_nxt;
    end
  end

endmodule

// File: rtl/exc_out_stage.sv
module exc_out_stage
  import exc_pkg::*;
#(
  parameter int N_PH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  exc_state_t      st_nxt,
  output logic [N_PH-1:0] ph_o,
  output logic [N_PH-1:0] ph_n_o,
  output logic            rev_o,
  output logic            step_o
);
  exc_drive_t       drv;
  logic [N_PH-1:0]  ph_d;
  logic [N_PH-1:0]  ph_idle;

  assign drv = exc_decode(st_nxt);

  always_comb begin
    ph_d    = '0;
    ph_idle = '0;
    ph_d[0]    = drv.fwd;
    ph_d[1]    = drv.rvs;
    ph_idle[0] = 1'b1;
  end

  // Each drive and its complement sit in separate flip-flops.
  for (genvar i = 0; i < N_PH; i++) begin : g_ph
    always_ff @(posedge clk) begin
      if (rst) begin
        ph_o[i]   <= ph_idle[i];
        ph_n_o[i] <= ~ph_idle[i];
      end else begin
        ph_o[i]   <= ph_d[i];
        ph_n_o[i] <= ~ph_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rev_o  <= 1'b0;
      step_o <= 1'b0;
    end else begin
      rev_o  <= drv.rev;
      step_o <= drv.step;
    end
  end

endmodule

// File: rtl/bridge_exc_phase_gen.sv
module bridge_exc_phase_gen
  import exc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_en,
  input  logic [CNT_W-1:0] half_period,
  output logic             fwd_o,
  output logic             fwd_n_o,
  output logic             rvs_o,
  output logic             rvs_n_o,
  output logic             pol_rev_o,
  output logic             pol_step_o
);
  localparam int N_PH = 2;

  exc_state_t       st_nxt;
  logic             len_load;
  logic             go_zero;
  logic             go_one;
  logic             go_inc;
  logic             at_last;
  logic [CNT_W-1:0] last_idx;
  logic [N_PH-1:0]  ph;
  logic [N_PH-1:0]  ph_n;

  exc_len_latch #(.CNT_W(CNT_W)) len_i (
    .clk(clk), .rst(rst), .load(len_load),
    .half_period(half_period), .last_idx(last_idx)
  );

  exc_half_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst(rst), .go_zero(go_zero), .go_one(go_one),
    .go_inc(go_inc), .last_idx(last_idx), .at_last(at_last)
  );

  exc_phase_fsm fsm_i (
    .clk(clk), .rst(rst), .exc_en(exc_en), .at_last(at_last),
    .st_nxt(st_nxt), .len_load(len_load), .go_zero(go_zero),
    .go_one(go_one), .go_inc(go_inc)
  );

  exc_out_stage #(.N_PH(N_PH)) out_i (
    .clk(clk), .rst(rst), .st_nxt(st_nxt),
    .ph_o(ph), .ph_n_o(ph_n), .rev_o(pol_rev_o), .step_o(pol_step_o)
  );

  assign fwd_o   = ph[0];
  assign rvs_o   = ph[1];
  assign fwd_n_o = ph_n[0];
  assign rvs_n_o = ph_n[1];

endmodule

// File: rtl/exc_phase_chk.sv
module exc_phase_chk (
  input logic clk,
  input logic rst,
  input logic fwd_o,
  input logic fwd_n_o,
  input logic rvs_o,
  input logic rvs_n_o,
  input logic pol_rev_o,
  input logic pol_step_o
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(fwd_o && rvs_o));

  // R5
  rvs_rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rvs_o) |-> $past(!fwd_o));

  // R5
  fwd_rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fwd_o) |-> $past(!rvs_o));

  // R5
  dead_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!fwd_o && !rvs_o) |=> (fwd_o || rvs_o));

  // R6
  fwd_compl_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_n_o == !fwd_o);

  // R6
  rvs_compl_chk: assert property (@(posedge clk) disable iff (rst)
    rvs_n_o == !rvs_o);

  // R7
  flag_follows_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_o || rvs_o) |-> (pol_rev_o == rvs_o));

  // R7
  step_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    pol_step_o |-> (pol_rev_o != $past(pol_rev_o)));

  // R7
  change_has_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pol_rev_o != $past(pol_rev_o)) |-> pol_step_o);

endmodule

bind bridge_exc_phase_gen exc_phase_chk chk_i (
  .clk(clk), .rst(rst), .fwd_o(fwd_o), .fwd_n_o(fwd_n_o),
  .rvs_o(rvs_o), .rvs_n_o(rvs_n_o), .pol_rev_o(pol_rev_o),
  .pol_step_o(pol_step_o)
);

// File: tb/bridge_exc_phase_gen_tb_top.sv
`timescale 1ns/1ps
module bridge_exc_phase_gen_tb_top;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             exc_en = 1'b0;
  logic [CNT_W-1:0] half_period = CNT_W'(4);
  logic fwd_o, fwd_n_o, rvs_o, rvs_n_o, pol_rev_o, pol_step_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bridge_exc_phase_gen #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .exc_en(exc_en), .half_period(half_period),
    .fwd_o(fwd_o), .fwd_n_o(fwd_n_o), .rvs_o(rvs_o), .rvs_n_o(rvs_n_o),
    .pol_rev_o(pol_rev_o), .pol_step_o(pol_step_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Compares {fwd, rvs, rev flag, step} and both complements.
  task automatic chk(input string req, input int k, input logic [3:0] exp);
    logic [3:0] act;
    act = {fwd_o, rvs_o, pol_rev_o, pol_step_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d {fwd,rvs,rev,step} act=%b exp=%b", req, k, act, exp);
    end
    n_chk++;
    if ({fwd_n_o, rvs_n_o} !== ~{fwd_o, rvs_o}) begin
      n_fail++;
      $display("FAIL R6 k=%0d inverted act=%b exp=%b", k,
               {fwd_n_o, rvs_n_o}, ~{fwd_o, rvs_o});
    end
  endtask

  // Steady waveform for a length n when enabled from idle (R3, R4, R7).
  function automatic logic [3:0] steady(input int n, input int k);
    int j;
    if (k <= n) return 4'b1000;
    j = (k - n - 1) % (2 * n);
    if (j == 0) return 4'b0011;
    if (j < n) return 4'b0110;
    if (j == n) return 4'b0001;
    return 4'b1000;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    exc_en = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk("R1", 0, 4'b1000);
    step();
    chk("R1", 0, 4'b1000);
    half_period = CNT_W'(3);
    for (int k = 1; k <= 10; k++) begin
      step();
      chk("R2", k, 4'b1000);
    end
  endtask

  task automatic t_run(input int hp, input int n, input int cycles, input string req);
    do_reset();
    half_period = CNT_W'(hp);
    exc_en = 1'b1;
    for (int k = 1; k <= cycles; k++) begin
      step();
      chk(req, k, steady(n, k));
    end
    exc_en = 1'b0;
  endtask

  task automatic t_stop_fwd();
    do_reset();
    half_period = CNT_W'(4);
    exc_en = 1'b1;
    step(); step();
    exc_en = 1'b0;
    step(); chk("R8", 3, 4'b1000);
    step(); chk("R8", 4, 4'b1000);
    for (int k = 5; k <= 12; k++) begin
      step();
      chk("R8", k, 4'b1000);
    end
  endtask

  task automatic t_stop_rvs();
    do_reset();
    half_period = CNT_W'(4);
    exc_en = 1'b1;
    for (int k = 1; k <= 6; k++) step();
    exc_en = 1'b0;
    step(); chk("R8", 7, 4'b0110);
    step(); chk("R8", 8, 4'b0110);
    step(); chk("R8", 9, 4'b0001);
    for (int k = 10; k <= 15; k++) begin
      step();
      chk("R8", k, 4'b1000);
    end
  endtask

  task automatic t_len_change();
    do_reset();
    half_period = CNT_W'(4);
    exc_en = 1'b1;
    step(); step();
    half_period = CNT_W'(6);
    step(); chk("R9", 3, 4'b1000);
    step(); chk("R9", 4, 4'b1000);
    step(); chk("R9", 5, 4'b0011);
    for (int k = 6; k <= 10; k++) begin
      step();
      chk("R9", k, 4'b0110);
    end
    step(); chk("R9", 11, 4'b0001);
    exc_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_run(4, 4, 30, "R4");
    t_run(3, 3, 20, "R3");
    t_run(2, 2, 16, "R5");
    t_run(15, 15, 64, "R7");
    t_run(0, 2, 10, "R10");
    t_run(1, 2, 10, "R10");
    t_stop_fwd();
    t_stop_rvs();
    t_len_change();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule